// File: doc/BRIEF.md
# Dual-Band Multimodulus Prescaler

This block divides a fast input clock by 32, 33, 47 or 48. One select input chooses the band. The low band offers the 32/33 pair and the high band offers the 47/48 pair. A second input chooses the smaller or the larger ratio of that pair. The divider is a 2/3 cell followed by a sixteen-stage counting chain. Decode on the chain tells the cell, for each of its sixteen periods, whether to count two or three input cycles. In the low band the cell normally counts two and adds one cycle once per output period. In the high band it normally counts three and drops one cycle once per output period. The same decode serves both bands: the band select flips its sense.

The block feeds the programmable counters of an integer-N synthesizer loop. The divided clock goes downstream, and a strobe one input cycle wide marks the first cycle of every output period. The downstream counter uses that strobe to count periods. The whole block runs in one clock domain and uses enables, never gated clocks. The band and ratio inputs are captured only at a period boundary. A ratio change therefore never shortens or stretches the period already in progress.

Top module: `dualband_prescaler`

## Requirements
- R1: With `hi_band`=0 and `ratio_lo`=1 sampled, the output period is 32 input cycles.
- R2: With `hi_band`=0 and `ratio_lo`=0 sampled, the output period is 33 input cycles: fifteen 2-cycle cell periods and one 3-cycle cell period at the end of the output period.
- R3: With `hi_band`=1 and `ratio_lo`=1 sampled, the output period is 47 input cycles: fifteen 3-cycle cell periods and one 2-cycle cell period at the end of the output period.
- R4: With `hi_band`=1 and `ratio_lo`=0 sampled, the output period is 48 input cycles.
- R5: `tc_pulse` is high for exactly one input cycle per output period, and that cycle is the first cycle of the period.
- R6: `div_out` rises in the cycle in which `tc_pulse` is high. It stays high for the first half of the chain, which is 16 cycles for ratios 32 and 33 and 24 cycles for ratios 47 and 48. It is low for the rest of the period, so the duty cycle is within one input cycle of 50%.
- R7: `hi_band` and `ratio_lo` are sampled only on the clock edge that starts a period, which is the edge that raises `tc_pulse`. A change of these inputs in the middle of a period has no effect on the length of that period.
- R8: While `rst_n` is low, `div_out` is 1 and `tc_pulse` is 0, and both take these values without waiting for a clock edge. After `rst_n` rises, a two-stage release synchronizer holds the divider still for two edges. The first period then lasts 32 cycles whatever the inputs, so the first `tc_pulse` arrives on the 34th edge after release.
- R9: Successive periods each follow the configuration sampled at their own start. When the band changes between periods, every period is still complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| hi_band | input | 1 | Band select: 0 selects the 32/33 pair, 1 selects the 47/48 pair |
| ratio_lo | input | 1 | 1 selects the smaller ratio of the pair, 0 selects the larger |
| div_out | output | 1 | Divided clock, high in the first half of each period |
| tc_pulse | output | 1 | One-cycle strobe in the first cycle of each output period |

## Verification
The main function is tried with all four band/ratio settings. The settings are walked in two different orders, so a period of each ratio follows periods of other ratios, across both bands and within one band. The pair 32 and 33 tells apart the extra cycle added in the low band from none at all. The pair 47 and 48 shows whether the high band drops one cycle or none. The measured high time tells whether the odd cell period falls at the end of the period and not the start. Further tests change the inputs in mid-period, and apply reset both at start-up and in mid-run with the high band already selected. These tests separate sampling at the boundary from live use of the inputs, and separate the fixed first period after reset from a period that follows the inputs.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  localparam int unsigned DEF_CHAIN_BITS = 4;

  typedef enum logic {
    BAND_LOW  = 1'b0,
    BAND_HIGH = 1'b1
  } band_e;

  typedef struct packed {
    band_e band;
    logic  pick_lower;
  } ratio_cfg_t;

  localparam ratio_cfg_t CFG_RESET = '{band: BAND_LOW, pick_lower: 1'b1};

  function automatic int unsigned ratio_of(input int unsigned chain_bits,
                                           input ratio_cfg_t cfg);
    int unsigned len;
    len = 1 << chain_bits;
    if (cfg.band == BAND_HIGH) return cfg.pick_lower ? (3 * len - 1) : (3 * len);
    else                       return cfg.pick_lower ? (2 * len) : (2 * len + 1);
  endfunction

endpackage

// File: rtl/dbp_rst_sync.sv
module dbp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/dbp_cell23.sv
module dbp_cell23 (
  input  logic clk,
  input  logic rst_n,
  input  logic en_three,
  output logic cell_done
);

  logic [1:0] cnt_q;
  logic [1:0] cnt_d;
  logic       last;

  always_comb begin
    last  = en_three ? (cnt_q == 2'd2) : (cnt_q == 2'd1);
    cnt_d = last ? 2'd0 : (cnt_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  assign cell_done = last;

endmodule

// File: rtl/dbp_chain.sv
module dbp_chain #(
  parameter int unsigned CHAIN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  output logic [CHAIN_BITS-1:0] cnt,
  output logic                  at_last,
  output logic                  wrap
);

  logic [CHAIN_BITS-1:0] cnt_q;
  logic [CHAIN_BITS-1:0] cnt_d;
  logic [CHAIN_BITS:0]   carry;

  assign carry[0] = adv;

  for (genvar i = 0; i < CHAIN_BITS; i++) begin : g_stage
    assign carry[i+1] = carry[i] & cnt_q[i];
    assign cnt_d[i]   = cnt_q[i] ^ carry[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_last = &cnt_q;
  assign wrap    = carry[CHAIN_BITS];

endmodule

// File: rtl/dualband_prescaler.sv
module dualband_prescaler #(
  parameter int unsigned CHAIN_BITS = dbp_pkg::DEF_CHAIN_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_band,
  input  logic ratio_lo,
  output logic div_out,
  output logic tc_pulse
);

  import dbp_pkg::*;

  localparam int unsigned MSB = CHAIN_BITS - 1;

  logic                  rst_core_n;
  ratio_cfg_t            cfg_q;
  ratio_cfg_t            cfg_d;
  logic                  odd_slot;
  logic                  en_three;
  logic                  cell_done;
  logic [CHAIN_BITS-1:0] chain_cnt;
  logic                  at_last;
  logic                  wrap;
  logic                  tc_q;

  dbp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Low band: extra cycle when the larger ratio is picked.
  // High band: one short cell period when the smaller ratio is picked.
  always_comb begin
    odd_slot = at_last & ((cfg_q.band == BAND_HIGH) ? cfg_q.pick_lower : ~cfg_q.pick_lower);
    en_three = (cfg_q.band == BAND_HIGH) ^ odd_slot;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (wrap) begin
      cfg_d.band       = hi_band ? BAND_HIGH : BAND_LOW;
      cfg_d.pick_lower = ratio_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cfg_q <= CFG_RESET;
      tc_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      tc_q  <= wrap;
    end
  end

  dbp_cell23 u_cell (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en_three  (en_three),
    .cell_done (cell_done)
  );

  dbp_chain #(.CHAIN_BITS(CHAIN_BITS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .adv     (cell_done),
    .cnt     (chain_cnt),
    .at_last (at_last),
    .wrap    (wrap)
  );

  assign div_out  = ~chain_cnt[MSB];
  assign tc_pulse = tc_q;

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int unsigned CHAIN_BITS = dbp_pkg::DEF_CHAIN_BITS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hi_band,
  input logic                ratio_lo,
  input logic                div_out,
  input logic                tc_pulse,
  input dbp_pkg::ratio_cfg_t cfg_q
);

  import dbp_pkg::*;

  localparam int unsigned MAX_RATIO = 3 * (1 << CHAIN_BITS);
  localparam int unsigned GAP_W     = $clog2(MAX_RATIO + 2);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (tc_pulse) gap_q <= GAP_W'(1);
    else               gap_q <= gap_q + GAP_W'(1);
  end

  // R1 R2 R3 R4 R9: each finished period matches the ratio sampled at its start
  p_period_ratio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (32'(gap_q) == ratio_of(CHAIN_BITS, $past(cfg_q))));

  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(gap_q) <= MAX_RATIO);

  p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  p_rise_with_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_out) |-> tc_pulse);

  p_high_at_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> div_out);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_pulse |-> $stable(cfg_q));

  p_cfg_sampled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (cfg_q.pick_lower == $past(ratio_lo)) && ((cfg_q.band == BAND_HIGH) == $past(hi_band)));

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_idle_r8: assert (div_out === 1'b1 && tc_pulse === 1'b0);
    end
  end

endmodule

bind dualband_prescaler dbp_checker #(.CHAIN_BITS(CHAIN_BITS)) u_dbp_checker (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .hi_band  (hi_band),
  .ratio_lo (ratio_lo),
  .div_out  (div_out),
  .tc_pulse (tc_pulse),
  .cfg_q    (cfg_q)
);

// File: tb/test_dualband_prescaler.sv
module test_dualband_prescaler;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic band;
    logic lo;
    int   len;
    int   hi;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 32, 16},   // R1
    '{1'b0, 1'b0, 33, 16},   // R2
    '{1'b1, 1'b1, 47, 24},   // R3
    '{1'b1, 1'b0, 48, 24},   // R4
    '{1'b0, 1'b1, 32, 16},   // R9 band change
    '{1'b1, 1'b0, 48, 24},
    '{1'b0, 1'b0, 33, 16},
    '{1'b1, 1'b1, 47, 24}
  };

  logic clk;
  logic rst_n;
  logic hi_band;
  logic ratio_lo;
  logic div_out;
  logic tc_pulse;

  int checks;
  int fails;

  dualband_prescaler i_dualband_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_band  (hi_band),
    .ratio_lo (ratio_lo),
    .div_out  (div_out),
    .tc_pulse (tc_pulse)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tc();
    do @(negedge clk); while (tc_pulse !== 1'b1);
  endtask

  // Called at a negedge where tc_pulse is high; returns at the next such negedge.
  task automatic run_period(output int len, output int hi);
    len = 1;
    hi  = (div_out === 1'b1) ? 1 : 0;
    forever begin
      @(negedge clk);
      if (tc_pulse === 1'b1) break;
      len++;
      if (div_out === 1'b1) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int len;
    int hi;
    int n;
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    hi_band  = 1'b1;
    ratio_lo = 1'b1;
    repeat (3) @(negedge clk);
    check(div_out === 1'b1, "R8 div_out in reset", int'(div_out), 1);
    check(tc_pulse === 1'b0, "R8 tc_pulse in reset", int'(tc_pulse), 0);

    // R8: release with high band requested; first period still 32
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (tc_pulse !== 1'b1);
    check(n == 34, "R8 first strobe edge after release", n, 34);
    run_period(len, hi);
    check(len == 47, "R8 R3 period after first boundary", len, 47);

    // Table walk: R1 R2 R3 R4 R6 R9
    foreach (VECS[i]) begin
      hi_band  = VECS[i].band;
      ratio_lo = VECS[i].lo;
      wait_tc();
      run_period(len, hi);
      check(len == VECS[i].len, $sformatf("R1-4/R9 period vec%0d", i), len, VECS[i].len);
      check(hi == VECS[i].hi, $sformatf("R6 high time vec%0d", i), hi, VECS[i].hi);
    end

    // R5: strobe is one cycle wide
    @(negedge clk);
    check(tc_pulse === 1'b0, "R5 strobe width", int'(tc_pulse), 0);

    // R7: mid-period change ignored
    hi_band  = 1'b0;
    ratio_lo = 1'b1;
    wait_tc();
    wait_tc();
    len = 1;
    repeat (5) begin @(negedge clk); len++; end
    hi_band  = 1'b1;
    ratio_lo = 1'b0;
    forever begin
      @(negedge clk);
      if (tc_pulse === 1'b1) break;
      len++;
    end
    check(len == 32, "R7 period after mid-period change", len, 32);
    run_period(len, hi);
    check(len == 48, "R7 next period uses new setting", len, 48);

    // R8: asynchronous reset in mid-run
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(div_out === 1'b1, "R8 div_out async reset", int'(div_out), 1);
    check(tc_pulse === 1'b0, "R8 tc_pulse async reset", int'(tc_pulse), 0);
    repeat (4) @(negedge clk);
    hi_band  = 1'b1;
    ratio_lo = 1'b0;
    rst_n    = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (tc_pulse !== 1'b1);
    check(n == 34, "R8 first strobe after mid-run reset", n, 34);
    run_period(len, hi);
    check(len == 48, "R8 R4 period after reset boundary", len, 48);
    check(hi == 24, "R6 high time ratio 48", hi, 24);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule